// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block sends a frame of serial data words on a single output, one bit per cycle of its bit clock. Software-side logic writes each word into a one-entry holding register. The transmitter moves the word into a shift stage when that word is needed. Each frame waits for a selectable start event, then for a programmable number of idle cycles. It can then send an optional synchronization field taken from a configuration input. After that, a programmed number of data words follow back to back.

Word length, words per frame, bit order and the level driven while idle are all configuration inputs. The writer paces itself on two flags. `tx_ready` shows that the holding register can take a new word. `tx_empty` shows that neither the holding register nor the shift stage has anything left to send. All inputs are sampled on the bit clock. Clock generation and any register map sit outside the block.

Top module: `fsst_tx`

## Requirements
- R1: After reset, `tx_out` equals `idle_lvl`, and `tx_ready` and `tx_empty` are both 1.
- R2: `start_sel` picks the start event. 0 starts a frame when the holding register is full. 1 starts on a rising edge of `frm_in`, 2 on a falling edge, and 3 on either edge. An event is ignored while `tx_en` is 0 or while a frame is in progress: the output stays at the idle level and the held word is not taken.
- R3: Suppose the start event is sampled at clock edge E. Then the first bit of the frame is driven in the cycle after edge E+`start_dly`. Before that, `tx_out` holds `idle_lvl`, and a delay of 0 puts the first bit right after E.
- R4: When `sync_en` is 1, `sync_lenm1`+1 bits of `sync_pat` are sent before the first data word, in the same bit order as the data. When `sync_en` is 0, data follows the delay directly.
- R5: Each word sends `data_lenm1`+1 bits, one per cycle (1 to 32 bits). With `msb_first`=1 the order runs from bit `data_lenm1` down to bit 0; otherwise from bit 0 upward.
- R6: A frame carries `word_cntm1`+1 words (1 to 16) with no gap between them. After the last word, `tx_out` returns to `idle_lvl`.
- R7: If the holding register is empty when the sync field or a word ends, the frame stops there and `tx_out` returns to `idle_lvl`.
- R8: A write makes `tx_ready` 0. A move of the held word into the shift stage makes it 1 again. If a write and a move happen in the same cycle, the new word stays held and `tx_ready` stays 0.
- R9: `tx_empty` is 1 only when the holding register and the shift stage are both empty.
- R10: Dropping `tx_en` aborts any frame at the next edge and `tx_out` goes to `idle_lvl`. A word still in the holding register is kept for a later frame.
- R11: Between frames, `tx_out` drives `idle_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmitter enable |
| start_sel | input | 2 | Start event select |
| frm_in | input | 1 | External frame start signal |
| start_dly | input | DLY_W | Idle cycles between start event and first bit |
| sync_en | input | 1 | Send sync field before data |
| sync_lenm1 | input | log2(SYNC_W) | Sync field length minus one |
| sync_pat | input | SYNC_W | Sync field bits |
| data_lenm1 | input | log2(DW) | Word length minus one |
| word_cntm1 | input | log2(MAX_WORDS) | Words per frame minus one |
| idle_lvl | input | 1 | Level driven when not sending |
| msb_first | input | 1 | 1: most significant bit first |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW | Word to hold |
| tx_out | output | 1 | Serial data output |
| tx_ready | output | 1 | Holding register can accept a word |
| tx_empty | output | 1 | Holding register and shift stage both empty |

## Verification
Some properties are checked on every cycle by the assertions. The output sits at the idle level while waiting or delaying. A disable clears the shift stage. A move into the shift stage only happens from a full holding register. `tx_ready` only rises after such a move, and the bit counter never passes the loaded length.

Other properties can only be shown by the bench's scenarios. These are the exact bit streams for each start source, delay, sync setting, length, word count and bit order, and the cycle where the first bit appears. The bench also covers frames cut short by an empty holding register, a write landing on the same edge as a move, and a held word surviving an abort to be sent by the next frame.

// File: rtl/fsst_pkg.sv
package fsst_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_SYNC  = 2'd2,
      ST_DATA  = 2'd3
   } fsst_state_t;

   typedef enum logic [1:0] {
      SRC_HOLD = 2'd0,
      SRC_RISE = 2'd1,
      SRC_FALL = 2'd2,
      SRC_EDGE = 2'd3
   } fsst_src_t;
endpackage

// File: rtl/fsst_start_det.sv
module fsst_start_det
   import fsst_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       frm_in,
   input  logic       hold_full,
   output logic       evt_o
);
   logic frm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frm_q <= 1'b0;
      else        frm_q <= frm_in;
   end

   always_comb begin
      unique case (fsst_src_t'(sel))
         SRC_HOLD: evt_o = hold_full;
         SRC_RISE: evt_o = frm_in & ~frm_q;
         SRC_FALL: evt_o = ~frm_in & frm_q;
         SRC_EDGE: evt_o = frm_in ^ frm_q;
      endcase
   end
endmodule

// File: rtl/fsst_hold.sv
module fsst_hold #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          take_i,
   output logic [DW-1:0] data_o,
   output logic          full_o
);
   logic [DW-1:0] data_q;
   logic          full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
      end else begin
         if (wr_en) data_q <= wr_data;
         if (wr_en)       full_q <= 1'b1;
         else if (take_i) full_q <= 1'b0;
      end
   end

   assign data_o = data_q;
   assign full_o = full_q;

   assert_take_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> full_q);
   assert_write_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> full_q);
endmodule

// File: rtl/fsst_shifter.sv
module fsst_shifter #(
   parameter int DW      = 32,
   parameter bit OUT_REG = 1'b0,
   localparam int LW     = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort,
   input  logic          load,
   input  logic [DW-1:0] ld_word,
   input  logic [LW-1:0] ld_lenm1,
   input  logic          msb_first,
   input  logic          idle_lvl,
   output logic          bit_o,
   output logic          busy_o,
   output logic          last_o
);
   logic [DW-1:0] sreg_q;
   logic [LW-1:0] blen_q;
   logic [LW-1:0] bcnt_q;
   logic          msb_q;
   logic          busy_q;
   logic          last;
   logic          raw_bit;

   assign last = busy_q && (bcnt_q == blen_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         blen_q <= '0;
         bcnt_q <= '0;
         msb_q  <= 1'b0;
         busy_q <= 1'b0;
      end else if (abort) begin
         busy_q <= 1'b0;
      end else if (load) begin
         sreg_q <= ld_word;
         blen_q <= ld_lenm1;
         bcnt_q <= '0;
         msb_q  <= msb_first;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (last) begin
            busy_q <= 1'b0;
         end else begin
            bcnt_q <= bcnt_q + 1'b1;
            sreg_q <= msb_q ? (sreg_q << 1) : (sreg_q >> 1);
         end
      end
   end

   always_comb begin
      if (!busy_q)    raw_bit = idle_lvl;
      else if (msb_q) raw_bit = sreg_q[blen_q];
      else            raw_bit = sreg_q[0];
   end

   generate
      if (OUT_REG) begin : g_out_reg
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= raw_bit;
         end
         assign bit_o = out_q;
      end else begin : g_out_comb
         assign bit_o = raw_bit;
      end
   endgenerate

   assign busy_o = busy_q;
   assign last_o = last;

   assert_bitcnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (bcnt_q <= blen_q));
   assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy_q);
endmodule

// File: rtl/fsst_tx.sv
module fsst_tx
   import fsst_pkg::*;
#(
   parameter int DW        = 32,
   parameter int MAX_WORDS = 16,
   parameter int DLY_W     = 8,
   parameter int SYNC_W    = 16,
   parameter bit OUT_REG   = 1'b0,
   localparam int LW       = $clog2(DW),
   localparam int WW       = $clog2(MAX_WORDS),
   localparam int SLW      = $clog2(SYNC_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic [1:0]        start_sel,
   input  logic              frm_in,
   input  logic [DLY_W-1:0]  start_dly,
   input  logic              sync_en,
   input  logic [SLW-1:0]    sync_lenm1,
   input  logic [SYNC_W-1:0] sync_pat,
   input  logic [LW-1:0]     data_lenm1,
   input  logic [WW-1:0]     word_cntm1,
   input  logic              idle_lvl,
   input  logic              msb_first,
   input  logic              wr_en,
   input  logic [DW-1:0]     wr_data,
   output logic              tx_out,
   output logic              tx_ready,
   output logic              tx_empty
);
   initial begin
      assert_param_dw: assert (DW >= 2 && (1 << LW) == DW)
         else $error("DW must be a power of two of at least 2");
      assert_param_sync: assert (SYNC_W >= 2 && SYNC_W <= DW && (1 << SLW) == SYNC_W)
         else $error("SYNC_W must be a power of two no wider than DW");
      assert_param_words: assert (MAX_WORDS >= 2 && (1 << WW) == MAX_WORDS)
         else $error("MAX_WORDS must be a power of two of at least 2");
      assert_param_dly: assert (DLY_W >= 1)
         else $error("DLY_W must be at least 1");
   end

   fsst_state_t      st_q, st_d;
   logic [DLY_W-1:0] dcnt_q, dcnt_d;
   logic [WW-1:0]    wdone_q, wdone_d;

   logic          start_evt;
   logic [DW-1:0] hold_data;
   logic          hold_full;
   logic          take;
   logic          sh_load;
   logic [DW-1:0] sh_word;
   logic [LW-1:0] sh_lenm1;
   logic          sh_bit, sh_busy, sh_last;
   logic          launch, want_word, first_word;

   fsst_start_det u_start (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (start_sel),
      .frm_in    (frm_in),
      .hold_full (hold_full),
      .evt_o     (start_evt)
   );

   fsst_hold #(.DW(DW)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take_i  (take),
      .data_o  (hold_data),
      .full_o  (hold_full)
   );

   fsst_shifter #(.DW(DW), .OUT_REG(OUT_REG)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort     (!tx_en),
      .load      (sh_load),
      .ld_word   (sh_word),
      .ld_lenm1  (sh_lenm1),
      .msb_first (msb_first),
      .idle_lvl  (idle_lvl),
      .bit_o     (sh_bit),
      .busy_o    (sh_busy),
      .last_o    (sh_last)
   );

   always_comb begin
      st_d       = st_q;
      dcnt_d     = dcnt_q;
      wdone_d    = wdone_q;
      sh_load    = 1'b0;
      sh_word    = hold_data;
      sh_lenm1   = data_lenm1;
      take       = 1'b0;
      launch     = 1'b0;
      want_word  = 1'b0;
      first_word = 1'b0;

      unique case (st_q)
         ST_IDLE: begin
            if (start_evt) begin
               if (start_dly == '0) begin
                  launch = 1'b1;
               end else begin
                  st_d   = ST_DELAY;
                  dcnt_d = '0;
               end
            end
         end
         ST_DELAY: begin
            if ((dcnt_q + 1'b1) >= start_dly) launch = 1'b1;
            else                              dcnt_d = dcnt_q + 1'b1;
         end
         ST_SYNC: begin
            if (sh_last) begin
               want_word  = 1'b1;
               first_word = 1'b1;
            end
         end
         ST_DATA: begin
            if (sh_last) begin
               if (wdone_q == word_cntm1) st_d = ST_IDLE;
               else                       want_word = 1'b1;
            end
         end
      endcase

      if (launch) begin
         if (sync_en) begin
            sh_load  = 1'b1;
            sh_word  = DW'(sync_pat);
            sh_lenm1 = LW'(sync_lenm1);
            st_d     = ST_SYNC;
         end else begin
            want_word  = 1'b1;
            first_word = 1'b1;
         end
      end

      if (want_word) begin
         if (hold_full) begin
            sh_load = 1'b1;
            take    = 1'b1;
            st_d    = ST_DATA;
            wdone_d = first_word ? '0 : wdone_q + 1'b1;
         end else begin
            st_d = ST_IDLE;
         end
      end

      if (!tx_en) begin
         st_d    = ST_IDLE;
         sh_load = 1'b0;
         take    = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         dcnt_q  <= '0;
         wdone_q <= '0;
      end else begin
         st_q    <= st_d;
         dcnt_q  <= dcnt_d;
         wdone_q <= wdone_d;
      end
   end

   assign tx_out   = sh_bit;
   assign tx_ready = ~hold_full;
   assign tx_empty = ~hold_full & ~sh_busy;

   generate
      if (OUT_REG == 1'b0) begin : g_idle_chk
         assert_idle_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == ST_IDLE || st_q == ST_DELAY) |-> (tx_out == idle_lvl));
      end
   endgenerate

   assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (st_q == ST_IDLE && !sh_busy));
   assert_empty_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> tx_ready);
   assert_ready_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ready) |-> $past(take));
   assert_delay_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DELAY) |-> !sh_busy);
endmodule

// File: tb/sim_fsst_tx.sv
module sim_fsst_tx;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        tx_en;
   logic [1:0]  start_sel;
   logic        frm_in;
   logic [7:0]  start_dly;
   logic        sync_en;
   logic [3:0]  sync_lenm1;
   logic [15:0] sync_pat;
   logic [4:0]  data_lenm1;
   logic [3:0]  word_cntm1;
   logic        idle_lvl;
   logic        msb_first;
   logic        wr_en;
   logic [31:0] wr_data;
   logic        tx_out;
   logic        tx_ready;
   logic        tx_empty;

   int checks = 0;
   int fails  = 0;
   logic expv [0:511];

   always #5 clk = ~clk;

   fsst_tx u0 (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .start_sel(start_sel),
      .frm_in(frm_in), .start_dly(start_dly), .sync_en(sync_en),
      .sync_lenm1(sync_lenm1), .sync_pat(sync_pat), .data_lenm1(data_lenm1),
      .word_cntm1(word_cntm1), .idle_lvl(idle_lvl), .msb_first(msb_first),
      .wr_en(wr_en), .wr_data(wr_data), .tx_out(tx_out),
      .tx_ready(tx_ready), .tx_empty(tx_empty)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_frame(input int mode, input bit msb, input bit sen,
                            input int slm1, input int lenm1, input int wcm1,
                            input int dly, input bit idl, input int nsup,
                            input int seed, input string tag);
      logic [31:0] wd [0:15];
      logic [31:0] mask;
      logic [31:0] t;
      logic [15:0] spat;
      int  n;
      int  written;
      bit  bad;
      int  fi;
      logic got;
      mask = (lenm1 == 31) ? 32'hFFFF_FFFF : ((32'd1 << (lenm1 + 1)) - 32'd1);
      for (int w = 0; w < 16; w++) begin
         t = 32'h9E37_79B9 * 32'(w + 1) + 32'(seed) * 32'h0100_0193;
         wd[w] = t & mask;
      end
      spat = 16'hB4D2 ^ 16'(seed * 7);
      n = 0;
      for (int d = 0; d < dly; d++) begin expv[n] = idl; n++; end
      if (sen) begin
         for (int b = 0; b <= slm1; b++) begin
            expv[n] = spat[msb ? slm1 - b : b];
            n++;
         end
      end
      for (int w = 0; w <= wcm1; w++) begin
         if (w >= nsup) break;
         for (int b = 0; b <= lenm1; b++) begin
            expv[n] = wd[w][msb ? lenm1 - b : b];
            n++;
         end
      end
      for (int k = 0; k < 6; k++) begin expv[n] = idl; n++; end

      @(negedge clk);
      tx_en = 1'b0;
      start_sel = 2'(mode); msb_first = msb; sync_en = sen;
      sync_lenm1 = 4'(slm1); data_lenm1 = 5'(lenm1); word_cntm1 = 4'(wcm1);
      start_dly = 8'(dly); idle_lvl = idl; sync_pat = spat;
      frm_in = (mode == 2) ? 1'b1 : 1'b0;
      repeat (2) @(negedge clk);
      tx_en = 1'b1;
      written = 0;
      if (nsup > 0) begin
         wr_en = 1'b1; wr_data = wd[0]; written = 1;
         @(negedge clk);
         wr_en = 1'b0;
      end
      if (mode != 0) begin
         repeat (3) @(negedge clk);
         // R2: no start without the selected edge
         chk(tx_out === idl && tx_ready === (nsup == 0), "R2",
             "no start before edge", {30'd0, tx_ready, tx_out},
             {30'd0, (nsup == 0), idl});
         frm_in = ~frm_in;
      end
      bad = 1'b0; fi = 0; got = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (tx_out !== expv[i] && !bad) begin
            bad = 1'b1; fi = i; got = tx_out;
         end
         if (tx_ready && written < nsup) begin
            wr_en = 1'b1; wr_data = wd[written]; written++;
         end else begin
            wr_en = 1'b0;
         end
      end
      wr_en = 1'b0;
      chk(!bad, tag, $sformatf("stream bit %0d", fi), {31'd0, got}, {31'd0, expv[fi]});
      chk(tx_empty === 1'b1, "R9", "empty after frame", {31'd0, tx_empty}, 32'd1);
      tx_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int cyc;
      logic [7:0] bw;
      rst_n = 1'b0; tx_en = 1'b0; start_sel = 2'd1; frm_in = 1'b0;
      start_dly = 8'd0; sync_en = 1'b0; sync_lenm1 = 4'd0; sync_pat = 16'd0;
      data_lenm1 = 5'd7; word_cntm1 = 4'd0; idle_lvl = 1'b1; msb_first = 1'b0;
      wr_en = 1'b0; wr_data = 32'd0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(tx_out === 1'b1, "R1", "out after reset", {31'd0, tx_out}, 32'd1);
      chk(tx_ready === 1'b1, "R1", "ready after reset", {31'd0, tx_ready}, 32'd1);
      chk(tx_empty === 1'b1, "R1", "empty after reset", {31'd0, tx_empty}, 32'd1);

      // Sweep: start source, bit order, sync, length, word count, delay, idle level
      cyc = 0;
      for (int mode = 0; mode < 4; mode++)
         for (int msb = 0; msb < 2; msb++)
            for (int sen = 0; sen < 2; sen++)
               for (int li = 0; li < 3; li++)
                  for (int wi = 0; wi < 2; wi++) begin
                     cyc++;
                     run_frame(mode, msb[0], sen[0], (li * 5 + mode) % 16,
                               (li == 0) ? 1 : ((li == 1) ? 6 : 31),
                               wi * 2, (mode + li) % 3, 1'((mode + li + wi) % 2),
                               wi * 2 + 1, cyc, "R2 R3 R4 R5 R6 R11");
                  end

      // R7: holding register runs dry after the first of three words
      run_frame(1, 1'b1, 1'b0, 0, 7, 2, 0, 1'b0, 1, 500, "R7 word underrun");
      // R7: sync field with no data behind it
      run_frame(2, 1'b0, 1'b1, 9, 7, 0, 1, 1'b1, 0, 501, "R7 R4 sync underrun");
      // R5: one-bit word
      run_frame(3, 1'b0, 1'b0, 0, 0, 0, 0, 1'b1, 1, 502, "R5 one bit word");
      // R3: largest delay with longest sync field
      run_frame(1, 1'b1, 1'b1, 15, 31, 0, 255, 1'b0, 1, 503, "R3 R4 max delay");

      // R8: write on the same edge as a move into the shift stage
      @(negedge clk);
      tx_en = 1'b0; start_sel = 2'd1; msb_first = 1'b1; sync_en = 1'b0;
      data_lenm1 = 5'd3; word_cntm1 = 4'd2; start_dly = 8'd0; idle_lvl = 1'b1;
      frm_in = 1'b0;
      repeat (2) @(negedge clk);
      tx_en = 1'b1; wr_en = 1'b1; wr_data = 32'hA;
      @(negedge clk);
      wr_en = 1'b0;
      chk(tx_ready === 1'b0, "R8", "ready low after write", {31'd0, tx_ready}, 32'd0);
      chk(tx_empty === 1'b0, "R9", "not empty with held word", {31'd0, tx_empty}, 32'd0);
      frm_in = 1'b1;
      begin
         logic [11:0] pat;
         bit bad;
         pat = 12'b1010_0011_0101;
         bad = 1'b0;
         for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            if (i < 12) begin
               if (tx_out !== pat[11 - i]) bad = 1'b1;
            end else begin
               if (tx_out !== 1'b1) bad = 1'b1;
            end
            if (i == 0) begin
               chk(tx_ready === 1'b1 && tx_empty === 1'b0, "R9",
                   "ready but not empty while shifting",
                   {30'd0, tx_ready, tx_empty}, 32'd2);
               wr_en = 1'b1; wr_data = 32'h3;
            end else if (i == 3) begin
               wr_en = 1'b1; wr_data = 32'h5;
            end else begin
               wr_en = 1'b0;
            end
            if (i == 4)
               chk(tx_ready === 1'b0, "R8", "write and move same edge keeps ready low",
                   {31'd0, tx_ready}, 32'd0);
            if (i == 8)
               chk(tx_ready === 1'b1, "R8", "ready after last move",
                   {31'd0, tx_ready}, 32'd1);
         end
         chk(!bad, "R8 R6", "three word stream with overlapping write",
             {31'd0, bad}, 32'd0);
      end

      // R10: disable mid-frame keeps the held word
      @(negedge clk);
      tx_en = 1'b0; start_sel = 2'd1; msb_first = 1'b0; data_lenm1 = 5'd7;
      word_cntm1 = 4'd0; idle_lvl = 1'b1; frm_in = 1'b0;
      repeat (2) @(negedge clk);
      tx_en = 1'b1; wr_en = 1'b1; wr_data = 32'h5C;
      @(negedge clk);
      wr_en = 1'b0; frm_in = 1'b1;
      @(negedge clk);
      wr_en = 1'b1; wr_data = 32'hA3;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      chk(tx_out === 1'b1, "R10", "idle after disable", {31'd0, tx_out}, 32'd1);
      chk(tx_ready === 1'b0, "R10", "held word kept", {31'd0, tx_ready}, 32'd0);
      chk(tx_empty === 1'b0, "R10", "not empty with kept word", {31'd0, tx_empty}, 32'd0);
      start_sel = 2'd0;
      repeat (3) @(negedge clk);
      // R2: a full holding register does not start a frame while disabled
      chk(tx_out === 1'b1 && tx_ready === 1'b0, "R2", "no start while disabled",
          {30'd0, tx_ready, tx_out}, 32'd1);
      start_sel = 2'd1; frm_in = 1'b0;
      @(negedge clk);
      tx_en = 1'b1;
      @(negedge clk);
      frm_in = 1'b1;
      bw = 8'd0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         bw[i] = tx_out;
      end
      chk(bw === 8'hA3, "R10", "kept word sent by next frame", {24'd0, bw}, 32'hA3);
      @(negedge clk);
      chk(tx_out === 1'b1 && tx_empty === 1'b1, "R11", "idle and empty after frame",
          {30'd0, tx_empty, tx_out}, 32'd3);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule